// File: doc/BRIEF.md
# Masked Read-Clear Interrupt Aggregator

This block gathers event sources of a power-management controller into two 8-bit interrupt banks, a global bank and a charger bank. Each bank has a latch register that a read clears and a mask register. Global sources are single-bit levels. A rising edge of one of these levels, or on two of them a falling edge as well, sets a latch bit. Charger sources are multi-bit detail fields and single-bit status levels. A latch bit sets whenever the watched value changes.

The block drives an active-low, open-drain style interrupt request and a status copy of its internal drive. The request asserts only when an unmasked latch bit goes from 0 to 1. Once asserted, it stays asserted until every latch bit in both banks reads zero. Software uses a simple address/data port. The read data is combinational from the current state. A read of a latch address clears that latch at the clock edge that ends the read cycle.

Top module: `irqa_top`

## Requirements
- R1: After reset, both mask registers read 0xFF (address 2 is the global mask, address 3 is the charger mask), both latch registers read 0x00 (address 0 is global, address 1 is charger), irq_n is 1, and the request stays high while every mask bit is 1.
- R2: Global latch bit positions are as follows. Bit 6 is a rise of dropout_in. Bits 5 and 4 are rises of therm2_in and therm1_in. Bits 3 and 2 are the rise and fall of onkey_in. Bits 1 and 0 are the rise and fall of gpi_in. Bit 7 always reads 0, and a fall of dropout_in sets nothing.
- R3: Charger latch bit positions are as follows. Bit 2 sets on any change of in_dtl. Bit 1 sets on any change of chg_dtl. Bit 0 sets on any change of thm_dtl. Bit 3 sets on any change of treg_in. Bit 5 sets on any change of sysmin_in. Bits 7 and 6 always read 0.
- R4: Charger latch bit 4 sets when vmin_in changes or when ilim_in changes.
- R5: A read returns the latch value held before the read, and the latch clears at the edge that ends the read cycle. Writes to addresses 0 and 1 are ignored. Writes to addresses 2 and 3 load the mask.
- R6: irq_n goes low at the clock edge where an unmasked latch bit goes from 0 to 1. A bit that goes from 0 to 1 while masked leaves irq_n high.
- R7: Once low, irq_n returns high only at the edge where both latch registers become all zero. A latch bit that is set but masked keeps irq_n low.
- R8: irq_stat is 1 exactly when irq_n is 0.
- R9: An event that arrives in the same cycle as a read of its latch register remains set after that read.
- R10: Clearing a mask bit whose latch bit is already set does not assert irq_n.
- R11: In the first cycle after reset, the source values are taken as the baseline. A value that is already nonzero when reset releases sets no latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dropout_in | input | 1 | Regulator dropout status level |
| therm2_in | input | 1 | Thermal alarm 2 status level |
| therm1_in | input | 1 | Thermal alarm 1 status level |
| onkey_in | input | 1 | Debounced on-key level |
| gpi_in | input | 1 | Debounced general-purpose input level |
| in_dtl | input | 2 | Charger input status detail |
| chg_dtl | input | 4 | Charger state detail |
| thm_dtl | input | 3 | Thermistor detail |
| treg_in | input | 1 | Temperature-regulation status |
| sysmin_in | input | 1 | Minimum-system-voltage status |
| vmin_in | input | 1 | Minimum-input-voltage loop status |
| ilim_in | input | 1 | Input current-limit status |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_en | input | 1 | Write strobe for this cycle |
| addr | input | 2 | Register address: 0 global latch, 1 charger latch, 2 global mask, 3 charger mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq_n | output | 1 | Active-low interrupt request |
| irq_stat | output | 1 | Status copy of the interrupt drive, 1 when asserted |

## Verification
The bench sets a latch bit while it is masked and then clears the mask. A design that asserts the request from the level of the masked latch would pull irq_n low there. It clears one bank while a masked bit is still pending in the other, which catches a design that releases the request per bank or only on unmasked bits. It lands an event in the same cycle as a read of its latch, where a design that gives priority to the clear would lose the event. It also holds sources nonzero across reset, where a design whose change detectors reset to zero would post spurious charger and on-key interrupts.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
    localparam int BANK_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_GLAT = 2'd0,
        A_CLAT = 2'd1,
        A_GMSK = 2'd2,
        A_CMSK = 2'd3
    } addr_e;

    typedef enum int {
        DET_RISE,
        DET_FALL,
        DET_CHANGE
    } det_e;
endpackage

// File: rtl/irqa_detect.sv
module irqa_detect
    import irqa_pkg::*;
#(
    parameter int   W    = 1,
    parameter det_e MODE = DET_CHANGE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] val,
    output logic         ev
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic         primed;
    } det_st_t;

    det_st_t s_d, s_q;
    logic    hit;

    generate
        if (MODE == DET_RISE) begin : g_rise
            assign hit = |(val & ~s_q.prev);
        end else if (MODE == DET_FALL) begin : g_fall
            assign hit = |(~val & s_q.prev);
        end else begin : g_change
            assign hit = (val != s_q.prev);
        end
    endgenerate

    always_comb begin
        s_d        = s_q;
        s_d.prev   = val;
        s_d.primed = 1'b1;
    end

    // the first cycle after reset only captures the baseline
    assign ev = hit & s_q.primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/irqa_bank.sv
module irqa_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         rd_clr,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] latch_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] latch_next,
    output logic [W-1:0] new_set
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] mask;
    } bank_st_t;

    bank_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // a new event wins over the clear of the same cycle
        s_d.latch = (rd_clr ? '0 : s_q.latch) | ev;
        if (mask_we) begin
            s_d.mask = mask_wdata;
        end
        new_set    = s_d.latch & ~s_q.latch & ~s_q.mask;
        latch_next = s_d.latch;
    end

    assign latch_o = s_q.latch;
    assign mask_o  = s_q.mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.latch <= '0;
            s_q.mask  <= '1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/irqa_top.sv
module irqa_top
    import irqa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dropout_in,
    input  logic              therm2_in,
    input  logic              therm1_in,
    input  logic              onkey_in,
    input  logic              gpi_in,
    input  logic [1:0]        in_dtl,
    input  logic [3:0]        chg_dtl,
    input  logic [2:0]        thm_dtl,
    input  logic              treg_in,
    input  logic              sysmin_in,
    input  logic              vmin_in,
    input  logic              ilim_in,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rdata,
    output logic              irq_n,
    output logic              irq_stat
);
    localparam int N_RISE = 3;
    localparam int N_BOTH = 2;

    logic [BANK_W-1:0] g_ev, c_ev;
    logic [BANK_W-1:0] g_latch, g_mask, g_next, g_new;
    logic [BANK_W-1:0] c_latch, c_mask, c_next, c_new;
    logic [N_RISE-1:0] rise_lvl;
    logic [N_BOTH-1:0] both_lvl;

    // global bank: bits 4..6 are rises only, bits 0..3 are rise/fall pairs
    assign rise_lvl = {dropout_in, therm2_in, therm1_in};
    assign both_lvl = {onkey_in, gpi_in};

    generate
        for (genvar i = 0; i < N_RISE; i++) begin : g_rise_src
            irqa_detect #(.W(1), .MODE(DET_RISE)) u_det (
                .clk(clk), .rst_n(rst_n), .val(rise_lvl[i]), .ev(g_ev[2*N_BOTH+i])
            );
        end
        for (genvar i = 0; i < N_BOTH; i++) begin : g_edge_src
            irqa_detect #(.W(1), .MODE(DET_RISE)) u_rise (
                .clk(clk), .rst_n(rst_n), .val(both_lvl[i]), .ev(g_ev[2*i+1])
            );
            irqa_detect #(.W(1), .MODE(DET_FALL)) u_fall (
                .clk(clk), .rst_n(rst_n), .val(both_lvl[i]), .ev(g_ev[2*i])
            );
        end
    endgenerate
    assign g_ev[BANK_W-1] = 1'b0;

    // charger bank: every source is a change detector
    irqa_detect #(.W(3), .MODE(DET_CHANGE)) u_thm (
        .clk(clk), .rst_n(rst_n), .val(thm_dtl), .ev(c_ev[0]));
    irqa_detect #(.W(4), .MODE(DET_CHANGE)) u_chg (
        .clk(clk), .rst_n(rst_n), .val(chg_dtl), .ev(c_ev[1]));
    irqa_detect #(.W(2), .MODE(DET_CHANGE)) u_in (
        .clk(clk), .rst_n(rst_n), .val(in_dtl), .ev(c_ev[2]));
    irqa_detect #(.W(1), .MODE(DET_CHANGE)) u_treg (
        .clk(clk), .rst_n(rst_n), .val(treg_in), .ev(c_ev[3]));
    irqa_detect #(.W(2), .MODE(DET_CHANGE)) u_lim (
        .clk(clk), .rst_n(rst_n), .val({vmin_in, ilim_in}), .ev(c_ev[4]));
    irqa_detect #(.W(1), .MODE(DET_CHANGE)) u_sysmin (
        .clk(clk), .rst_n(rst_n), .val(sysmin_in), .ev(c_ev[5]));
    assign c_ev[BANK_W-1:6] = '0;

    irqa_bank #(.W(BANK_W)) u_gbank (
        .clk(clk), .rst_n(rst_n), .ev(g_ev),
        .rd_clr(rd_en && (addr == A_GLAT)),
        .mask_we(wr_en && (addr == A_GMSK)), .mask_wdata(wdata),
        .latch_o(g_latch), .mask_o(g_mask), .latch_next(g_next), .new_set(g_new)
    );

    irqa_bank #(.W(BANK_W)) u_cbank (
        .clk(clk), .rst_n(rst_n), .ev(c_ev),
        .rd_clr(rd_en && (addr == A_CLAT)),
        .mask_we(wr_en && (addr == A_CMSK)), .mask_wdata(wdata),
        .latch_o(c_latch), .mask_o(c_mask), .latch_next(c_next), .new_set(c_new)
    );

    typedef struct packed {
        logic act;
    } irq_st_t;

    irq_st_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.act = (r_q.act | (|g_new) | (|c_new)) & ((|g_next) | (|c_next));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr)
            A_GLAT:  rdata = g_latch;
            A_CLAT:  rdata = c_latch;
            A_GMSK:  rdata = g_mask;
            default: rdata = c_mask;
        endcase
    end

    assign irq_n    = ~r_q.act;
    assign irq_stat = r_q.act;
endmodule

// File: rtl/irqa_chk.sv
module irqa_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_n,
    input logic [7:0] glat,
    input logic [7:0] clat,
    input logic [7:0] gmask,
    input logic [7:0] cmask
);
    a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && gmask == 8'hFF && cmask == 8'hFF) |=> irq_n);

    a_r7_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((glat | clat) != 8'h00));

    a_r6_assert_needs_new_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> (((glat & ~$past(glat) & ~$past(gmask)) |
                           (clat & ~$past(clat) & ~$past(cmask))) != 8'h00));

    a_r2_glb_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        glat[7] == 1'b0);

    a_r3_chg_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        clat[7:6] == 2'b00);
endmodule

bind irqa_top irqa_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n),
    .glat(g_latch), .clat(c_latch), .gmask(g_mask), .cmask(c_mask)
);

// File: tb/sim_irqa_top.sv
module sim_irqa_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dropout_in = 0, therm2_in = 0, therm1_in = 0, onkey_in = 0, gpi_in = 0;
    logic [1:0] in_dtl = '0;
    logic [3:0] chg_dtl = '0;
    logic [2:0] thm_dtl = '0;
    logic       treg_in = 0, sysmin_in = 0, vmin_in = 0, ilim_in = 0;
    logic       rd_en = 0, wr_en = 0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n, irq_stat;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    irqa_top u0 (
        .clk(clk), .rst_n(rst_n), .dropout_in(dropout_in), .therm2_in(therm2_in),
        .therm1_in(therm1_in), .onkey_in(onkey_in), .gpi_in(gpi_in), .in_dtl(in_dtl),
        .chg_dtl(chg_dtl), .thm_dtl(thm_dtl), .treg_in(treg_in), .sysmin_in(sysmin_in),
        .vmin_in(vmin_in), .ilim_in(ilim_in), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .irq_stat(irq_stat)
    );

    localparam logic [1:0] OP_NONE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

    typedef struct packed {
        logic [4:0]  g;      // {dropout, therm2, therm1, onkey, gpi}
        logic [12:0] c;      // {in[1:0], chg[3:0], thm[2:0], treg, sysmin, vmin, ilim}
        logic [1:0]  op;
        logic [1:0]  a;
        logic [7:0]  wd;
        logic [7:0]  exp_rd;
        logic        exp_irqn;
        logic [7:0]  req;
    } vec_t;

    localparam logic [12:0] C_IN   = 13'b01_0000_000_0000;
    localparam logic [12:0] C_CHG  = 13'b01_0101_000_0000;
    localparam logic [12:0] C_THM  = 13'b01_0101_011_0000;
    localparam logic [12:0] C_TRG  = 13'b01_0101_011_1000;
    localparam logic [12:0] C_SYS  = 13'b01_0101_011_1100;
    localparam logic [12:0] C_VMN  = 13'b01_0101_011_1110;
    localparam logic [12:0] C_ILM  = 13'b01_0101_011_1111;
    localparam logic [12:0] C_TR0  = 13'b01_0101_011_0111;
    localparam logic [12:0] C_SY0  = 13'b01_0101_011_0011;
    localparam int NV = 38;

    localparam vec_t VT [NV] = '{
        '{5'b00000, 13'd0, OP_RD, 2'd2, 8'h00, 8'hFF, 1'b1, 8'd1},  // R1 global mask
        '{5'b00000, 13'd0, OP_RD, 2'd3, 8'h00, 8'hFF, 1'b1, 8'd1},  // R1 charger mask
        '{5'b00000, 13'd0, OP_RD, 2'd0, 8'h00, 8'h00, 1'b1, 8'd1},  // R1 latch clear
        '{5'b10000, 13'd0, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b1, 8'd6}, // R6 masked rise
        '{5'b10000, 13'd0, OP_RD, 2'd0, 8'h00, 8'h40, 1'b1, 8'd2},  // R2 dropout bit 6
        '{5'b00000, 13'd0, OP_RD, 2'd0, 8'h00, 8'h00, 1'b1, 8'd5},  // R5 cleared by read
        '{5'b00000, 13'd0, OP_WR, 2'd2, 8'h00, 8'h00, 1'b1, 8'd5},  // R5 unmask global
        '{5'b00010, 13'd0, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd6}, // R6 onkey rise
        '{5'b00010, 13'd0, OP_RD, 2'd0, 8'h00, 8'h08, 1'b1, 8'd7},  // R7 release on clear
        '{5'b00011, 13'd0, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd2}, // R2 gpi rise
        '{5'b00001, 13'd0, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd2}, // R2 onkey fall
        '{5'b00001, 13'd0, OP_RD, 2'd0, 8'h00, 8'h06, 1'b1, 8'd2},  // R2 bits 2,1
        '{5'b01100, 13'd0, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd2}, // R2 therm + gpi fall
        '{5'b01100, 13'd0, OP_RD, 2'd0, 8'h00, 8'h31, 1'b1, 8'd2},  // R2 bits 5,4,0
        '{5'b01100, C_IN, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b1, 8'd6},  // R6 masked charger
        '{5'b01100, C_IN, OP_RD, 2'd1, 8'h00, 8'h04, 1'b1, 8'd3},   // R3 input detail bit 2
        '{5'b01100, C_IN, OP_WR, 2'd3, 8'h00, 8'h00, 1'b1, 8'd5},   // R5 unmask charger
        '{5'b01100, C_CHG, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd3}, // R3 state detail
        '{5'b01100, C_THM, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd3}, // R3 thermistor
        '{5'b01100, C_THM, OP_RD, 2'd1, 8'h00, 8'h03, 1'b1, 8'd3},  // R3 bits 1,0
        '{5'b01100, C_TRG, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd3}, // R3 treg
        '{5'b01100, C_SYS, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd3}, // R3 sysmin
        '{5'b01100, C_VMN, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd4}, // R4 vmin
        '{5'b01100, C_VMN, OP_RD, 2'd1, 8'h00, 8'h38, 1'b1, 8'd4},  // R4 bits 5,4,3
        '{5'b01100, C_ILM, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd4}, // R4 ilim
        '{5'b01100, C_ILM, OP_RD, 2'd1, 8'h00, 8'h10, 1'b1, 8'd4},  // R4 bit 4 only
        '{5'b01100, C_ILM, OP_WR, 2'd3, 8'hFF, 8'h00, 1'b1, 8'd5},  // R5 mask charger
        '{5'b01100, C_TR0, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b1, 8'd6}, // R6 masked treg
        '{5'b01101, C_TR0, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b0, 8'd6}, // R6 gpi rise
        '{5'b01101, C_TR0, OP_RD, 2'd0, 8'h00, 8'h02, 1'b0, 8'd7},  // R7 masked bit holds
        '{5'b01101, C_TR0, OP_RD, 2'd1, 8'h00, 8'h08, 1'b1, 8'd7},  // R7 all clear
        '{5'b01101, C_TR0, OP_WR, 2'd0, 8'hFF, 8'h00, 1'b1, 8'd5},  // R5 latch write
        '{5'b01101, C_TR0, OP_RD, 2'd0, 8'h00, 8'h00, 1'b1, 8'd5},  // R5 write ignored
        '{5'b01101, C_SY0, OP_NONE, 2'd0, 8'h00, 8'h00, 1'b1, 8'd10}, // R10 masked set
        '{5'b01101, C_SY0, OP_WR, 2'd3, 8'h00, 8'h00, 1'b1, 8'd10}, // R10 unmask late
        '{5'b01101, C_SY0, OP_RD, 2'd1, 8'h00, 8'h20, 1'b1, 8'd10}, // R10 bit 5 held
        '{5'b01100, C_SY0, OP_RD, 2'd0, 8'h00, 8'h00, 1'b0, 8'd9},  // R9 event during read
        '{5'b01100, C_SY0, OP_RD, 2'd0, 8'h00, 8'h01, 1'b1, 8'd9}   // R9 survived
    };

    task automatic check(input string what, input int req, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_read(input logic [1:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 check("read", req, rdata, exp);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {dropout_in, therm2_in, therm1_in, onkey_in, gpi_in} = VT[i].g;
            {in_dtl, chg_dtl, thm_dtl, treg_in, sysmin_in, vmin_in, ilim_in} = VT[i].c;
            rd_en = (VT[i].op == OP_RD);
            wr_en = (VT[i].op == OP_WR);
            addr  = VT[i].a;
            wdata = VT[i].wd;
            #1;
            if (VT[i].op == OP_RD) check("rdata", int'(VT[i].req), rdata, VT[i].exp_rd);
            @(posedge clk); #1;
            check("irq_n", int'(VT[i].req), {7'd0, irq_n}, {7'd0, VT[i].exp_irqn});
            check("irq_stat R8", 8, {7'd0, irq_stat}, {7'd0, ~VT[i].exp_irqn});
        end
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;

        // R11 and R1: sources held nonzero across reset
        rst_n = 1'b0;
        onkey_in = 1'b1;
        in_dtl = 2'b11;
        chg_dtl = 4'hA;
        repeat (3) @(negedge clk);
        #1 check("irq_n in reset R1", 1, {7'd0, irq_n}, 8'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read(2'd0, 8'h00, 11);   // R11 global baseline
        do_read(2'd1, 8'h00, 11);   // R11 charger baseline
        do_read(2'd2, 8'hFF, 1);    // R1 mask restored
        do_read(2'd3, 8'hFF, 1);    // R1 mask restored
        check("irq_n after reset R1", 1, {7'd0, irq_n}, 8'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule